// File: doc/BRIEF.md
# 64-bit XGMII Frame Receiver

This block sits behind a 64-bit XGMII receive path, where each clock carries eight byte lanes and one control flag per lane. It watches for a start control character in lane 0 or lane 4, discards the preamble and start-of-frame delimiter that follow, and delivers the payload as whole 64-bit words on a simple write port. Each output word is byte-reversed relative to lane order, so lane 0 lands in the most significant byte. When the start sits in lane 4, payload words are realigned: each output word joins the upper four lanes held from the previous cycle with the lower four lanes of the current cycle.

A terminate or error control character in any lane closes the frame. Payload bytes ahead of that lane are still written, with the unused byte positions forced to zero, and a one-cycle end pulse marks the end of the frame. At the moment the start character arrives, the block samples the sink's ready level. If the level is low, the whole frame is dropped without any write or end pulse. A new start character seen during a dropped frame begins a fresh frame immediately.

Top module: `xgmii_frame_rx`

## Requirements
- R1: After reset, and while no frame is active, `wr_valid` and `frame_end` are 0 and `wr_word` is all zeros.
- R2: Whenever `wr_valid` is 0, `wr_word` is all zeros.
- R3: For a frame that starts in lane 0 (control flag 1 and byte 0xFB in lane 0), every following payload word with no control characters is written one clock after it arrives. Input lane i (bits 8i+7:8i) appears at output bits 63-8i:56-8i.
- R4: For a frame that starts in lane 4, each output word is formed from the previous word's lanes 4–7 followed by the current word's lanes 0–3, taken as lanes 0–7 and byte-reversed as in R3. It is written one clock after the current word.
- R5: The word that carries the start character never causes a write. For a lane-4 start, the next word (preamble in lanes 0–2, delimiter in lane 3) causes a write only if a terminate or error falls inside its lanes 5–7.
- R6: A terminate character (control flag 1, byte 0xFD) in lane k closes the frame. The output clock that follows carries `frame_end`=1 for exactly one cycle, together with a write of the payload bytes ahead of lane k, with unused byte positions zero. No write occurs if no payload byte remains.
- R7: An error character (control flag 1, byte 0xFE) closes a frame exactly as a terminate does, including the end pulse.
- R8: `sink_ready` is sampled only in the cycle that carries the start character. If it is low, the frame produces no write and no end pulse. Changes to `sink_ready` during a frame have no effect.
- R9: A start character that arrives while a frame is being dropped begins a new frame, with `sink_ready` sampled again, and no terminate is needed in between.
- R10: In a lane-4 frame whose terminate falls in lanes 5–7 of a payload word, the full joined word is written first without an end pulse. The leftover lanes 4..k-1 are written in the next clock as the upper bytes of a word, together with `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 64 | Receive lanes, lane i in bits 8i+7:8i |
| rx_ctrl | input | 8 | Per-lane control flag, bit i for lane i |
| sink_ready | input | 1 | Sink accept level, sampled at frame start |
| wr_valid | output | 1 | Write enable for `wr_word` |
| wr_word | output | 64 | Byte-reversed payload word, zero when not writing |
| frame_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench sends terminate characters in lanes 0, 3, 4 and 6 and an error character in lane 5, so that partial-word masking and the choice of write-or-no-write are each tested. A design that miscounts the terminate lane would leak trailing idle bytes into the word or drop payload.

Lane-4 frames are tested with terminates in the delimiter word and at both sides of the lane-4 boundary of a payload word. A design that gets the hold register wrong would emit bytes from the wrong cycle, or lose the tail word that follows a late terminate.

Dropped frames are tested both with a normal terminate and with a restart partway through the frame, and `sink_ready` is toggled during an accepted frame. A design that sampled the ready level continuously would cut frames short. A design that waited for a terminate would miss the restarted frame.

// File: rtl/xgmii_frame_rx.sv
module xgmii_frame_rx (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] rx_data,
  input  logic [7:0]  rx_ctrl,
  input  logic        sink_ready,
  output logic        wr_valid,
  output logic [63:0] wr_word,
  output logic        frame_end
);
  localparam logic [7:0] C_START = 8'hFB;
  localparam logic [7:0] C_TERM  = 8'hFD;
  localparam logic [7:0] C_ERR   = 8'hFE;

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_DATA0 = 3'd1;
  localparam logic [2:0] S_PRE4  = 3'd2;
  localparam logic [2:0] S_DATA4 = 3'd3;
  localparam logic [2:0] S_TAIL  = 3'd4;
  localparam logic [2:0] S_DROP  = 3'd5;

  logic [2:0]  st_q, st_d;
  logic [31:0] hi_q, hi_d;
  logic        v_d, e_d;
  logic [63:0] w_d;
  logic [7:0]  ends;
  logic [3:0]  k;
  logic [63:0] kept;
  logic        start0, start4;

  function automatic logic [63:0] rev(input logic [63:0] x);
    for (int i = 0; i < 8; i++) rev[63-8*i -: 8] = x[8*i +: 8];
  endfunction

  assign start0 = rx_ctrl[0] && rx_data[7:0]   == C_START;
  assign start4 = rx_ctrl[4] && rx_data[39:32] == C_START;

  always_comb begin
    for (int i = 0; i < 8; i++)
      ends[i] = rx_ctrl[i] && (rx_data[8*i +: 8] == C_TERM || rx_data[8*i +: 8] == C_ERR);
    k = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (ends[i]) k = 4'(i);
    for (int i = 0; i < 8; i++)
      kept[8*i +: 8] = (4'(i) < k) ? rx_data[8*i +: 8] : 8'h00;
  end

  always_comb begin
    st_d = st_q;
    hi_d = hi_q;
    v_d  = 1'b0;
    e_d  = 1'b0;
    w_d  = '0;
    case (st_q)
      S_DATA0: begin
        if (k != 4'd0) begin
          v_d = 1'b1;
          w_d = rev(kept);
        end
        if (k != 4'd8) begin
          e_d  = 1'b1;
          st_d = S_IDLE;
        end
      end
      S_PRE4: begin
        if (k == 4'd8) begin
          hi_d = rx_data[63:32];
          st_d = S_DATA4;
        end else begin
          e_d  = 1'b1;
          st_d = S_IDLE;
          if (k > 4'd4) begin
            v_d = 1'b1;
            w_d = rev({32'h0, kept[63:32]});
          end
        end
      end
      S_DATA4: begin
        v_d = 1'b1;
        w_d = rev({kept[31:0], hi_q});
        if (k == 4'd8) begin
          hi_d = rx_data[63:32];
        end else if (k <= 4'd4) begin
          e_d  = 1'b1;
          st_d = S_IDLE;
        end else begin
          hi_d = kept[63:32];
          st_d = S_TAIL;
        end
      end
      default: begin
        if (st_q == S_TAIL) begin
          v_d = 1'b1;
          e_d = 1'b1;
          w_d = rev({32'h0, hi_q});
        end
        if (start0)
          st_d = sink_ready ? S_DATA0 : S_DROP;
        else if (start4)
          st_d = sink_ready ? S_PRE4 : S_DROP;
        else if (st_q != S_DROP || k != 4'd8)
          st_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      hi_q      <= '0;
      wr_valid  <= 1'b0;
      wr_word   <= '0;
      frame_end <= 1'b0;
    end else begin
      st_q      <= st_d;
      hi_q      <= hi_d;
      wr_valid  <= v_d;
      wr_word   <= w_d;
      frame_end <= e_d;
    end
  end
endmodule

// File: rtl/xgmii_frame_rx_chk.sv
module xgmii_frame_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_valid,
  input logic [63:0] wr_word,
  input logic        frame_end,
  input logic [2:0]  st
);
  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_PRE4 = 3'd2;
  localparam logic [2:0] S_TAIL = 3'd4;
  localparam logic [2:0] S_DROP = 3'd5;

  a_r2_zero_data: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> wr_word == 64'h0);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    st == S_IDLE |=> !wr_valid && !frame_end);

  a_r8_drop_silent: assert property (@(posedge clk) disable iff (rst)
    st == S_DROP |=> !wr_valid && !frame_end);

  a_r5_pre_no_write: assert property (@(posedge clk) disable iff (rst)
    st == S_PRE4 |=> !wr_valid || frame_end);

  a_r10_tail_flush: assert property (@(posedge clk) disable iff (rst)
    st == S_TAIL |=> wr_valid && frame_end);
endmodule

bind xgmii_frame_rx xgmii_frame_rx_chk u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
  .frame_end(frame_end), .st(st_q)
);

// File: tb/xgmii_frame_rx_test.sv
module xgmii_frame_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] rx_data = 64'h0707070707070707;
  logic [7:0]  rx_ctrl = 8'hFF;
  logic        sink_ready = 1'b0;
  logic        wr_valid, frame_end;
  logic [63:0] wr_word;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [63:0] IDLE_W = 64'h0707070707070707;
  localparam logic [63:0] ST0_W  = 64'hD5555555555555FB;
  localparam logic [63:0] ST4_W  = 64'h555555FB07070707;

  always #4 clk = ~clk;

  xgmii_frame_rx uut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .sink_ready(sink_ready), .wr_valid(wr_valid), .wr_word(wr_word),
    .frame_end(frame_end)
  );

  task automatic step(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    rx_data = d;
    rx_ctrl = c;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic ev, input logic [63:0] ew, input logic ee);
    checks++;
    if (wr_valid !== ev || wr_word !== ew || frame_end !== ee) begin
      fails++;
      $display("FAIL %s: got valid=%b word=%h end=%b, expected valid=%b word=%h end=%b",
               tag, wr_valid, wr_word, frame_end, ev, ew, ee);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", 0, 64'h0, 0);
    @(negedge clk) rst = 1'b0;
    step(IDLE_W, 8'hFF);
    chk("R1 idle after reset", 0, 64'h0, 0);
    step(IDLE_W, 8'hFF);
    chk("R1 idle", 0, 64'h0, 0);
  endtask

  task automatic t_lane0;
    sink_ready = 1'b1;
    step(ST0_W, 8'h01);
    chk("R5 start word", 0, 64'h0, 0);
    step(64'hEFCDAB8967452301, 8'h00);
    chk("R3 word 1", 1, 64'h0123456789ABCDEF, 0);
    step(64'h1122334455667788, 8'h00);
    chk("R3 word 2", 1, 64'h8877665544332211, 0);
    step(64'h07070707FDC3B2A1, 8'hF8);
    chk("R6 term lane 3", 1, 64'hA1B2C30000000000, 1);
    step(IDLE_W, 8'hFF);
    chk("R6 end single pulse", 0, 64'h0, 0);
  endtask

  task automatic t_error_and_lane0_term;
    sink_ready = 1'b1;
    step(ST0_W, 8'h01);
    step(64'h0707FE0504030201, 8'hE0);
    chk("R7 error lane 5", 1, 64'h0102030405000000, 1);
    step(ST0_W, 8'h01);
    step(64'h0F0E0D0C0B0A0908, 8'h00);
    chk("R3 word before term", 1, 64'h08090A0B0C0D0E0F, 0);
    step(64'h07070707070707FD, 8'hFF);
    chk("R6 term lane 0 no write", 0, 64'h0, 1);
    step(IDLE_W, 8'hFF);
    chk("R2 idle after end", 0, 64'h0, 0);
  endtask

  task automatic t_drop;
    sink_ready = 1'b0;
    step(ST0_W, 8'h01);
    sink_ready = 1'b1;
    step(64'hEFCDAB8967452301, 8'h00);
    chk("R8 dropped data", 0, 64'h0, 0);
    step(64'h07070707FD030201, 8'hF8);
    chk("R8 dropped term", 0, 64'h0, 0);
    step(IDLE_W, 8'hFF);
    chk("R8 after drop", 0, 64'h0, 0);
  endtask

  task automatic t_restart;
    sink_ready = 1'b0;
    step(ST0_W, 8'h01);
    step(64'h1111111111111111, 8'h00);
    chk("R8 dropped word", 0, 64'h0, 0);
    sink_ready = 1'b1;
    step(ST0_W, 8'h01);
    chk("R9 restart start word", 0, 64'h0, 0);
    step(64'h8877665544332211, 8'h00);
    chk("R9 restarted frame", 1, 64'h1122334455667788, 0);
    step(IDLE_W ^ 64'h00000000000000FA, 8'hFF);
    chk("R9 restarted end", 0, 64'h0, 1);
  endtask

  task automatic t_lane4;
    sink_ready = 1'b1;
    step(ST4_W, 8'h1F);
    chk("R5 lane4 start word", 0, 64'h0, 0);
    sink_ready = 1'b0;
    step(64'h67452311D5555555, 8'h00);
    chk("R5 delimiter word", 0, 64'h0, 0);
    step(64'h76543210EFCDAB89, 8'h00);
    chk("R4 joined word", 1, 64'h1123456789ABCDEF, 0);
    step(64'h070707FDFEDCBA98, 8'hF0);
    chk("R4 term lane 4", 1, 64'h1032547698BADCFE, 1);
    step(IDLE_W, 8'hFF);
    chk("R8 ready ignored mid-frame", 0, 64'h0, 0);
  endtask

  task automatic t_lane4_tail;
    sink_ready = 1'b1;
    step(ST4_W, 8'h1F);
    step(64'hA3A2A1A0D5555555, 8'h00);
    step(64'h07FDC1C0B3B2B1B0, 8'hC0);
    chk("R10 full word first", 1, 64'hA0A1A2A3B0B1B2B3, 0);
    step(IDLE_W, 8'hFF);
    chk("R10 tail word", 1, 64'hC0C1000000000000, 1);
    step(IDLE_W, 8'hFF);
    chk("R10 after tail", 0, 64'h0, 0);
    step(ST4_W, 8'h1F);
    step(64'h07FDE1E0D5555555, 8'hC0);
    chk("R5 term in delimiter word", 1, 64'hE0E1000000000000, 1);
    step(IDLE_W, 8'hFF);
    chk("R1 idle again", 0, 64'h0, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset;
    t_lane0;
    t_error_and_lane0_term;
    t_drop;
    t_restart;
    t_lane4;
    t_lane4_tail;
    done = 1'b1;
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary;
    end
  end
endmodule